// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block provides a small configuration space behind two byte-wide host I/O ports: an index port and a data port. The space stays locked until the host writes a fixed four-byte key to the index port. Once it is unlocked, the host writes a register number to the index port and then reads or writes that register through the data port. One index register selects a logical device, which banks part of the space. Identification registers report a chip identifier and a revision. Inside the general-purpose I/O logical device, two registers hold a 16-bit I/O base address. An exit command locks the space again.

The host bus has a 16-bit address, a write strobe and a read strobe. A strobe is an access lasting one cycle, and the bus never stalls, so there is no back-pressure. Read data is registered: it appears on the cycle after the read strobe and then holds until the next read. The selected logical device, the I/O base address and the lock state come out as plain outputs for downstream logic.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the space is locked, `cfg_unlocked` is 0, `ldn_sel` is 0x00, `gpio_base` is 0x0000 and `io_rdata` is 0xFF.
- R2: The space unlocks only after the bytes 0x87, 0x01, 0x55, 0x55 are written in that order to the index port (address 0x002E). The unlock shows on `cfg_unlocked` one cycle after the last key write.
- R3: A locked index-port write that breaks the key order resets the match. A 0x87 byte always counts as step one of the key, so 0x87 0x01 0x87 0x01 0x55 0x55 unlocks and 0x87 0x01 0x55 0x00 0x55 does not.
- R4: While locked, writes to the data port (address 0x002F) change no register, and data-port reads return 0xFF.
- R5: While unlocked, index register 0x07 holds the logical-device selector. It can be written and read back, and its value drives `ldn_sel`.
- R6: Index 0x20 reads the high byte of the chip identifier and 0x21 reads the low byte. Index 0x22 reads the revision in bits 3:0, with bits 7:4 at zero. All three registers ignore writes.
- R7: When `ldn_sel` is 7, index 0x62 (high byte) and 0x63 (low byte) read and write `gpio_base`. When any other device is selected, those indexes read 0x00 and writes to them are ignored.
- R8: Writing 0x02 to the index port and then 0x02 to the data port locks the space. Any other data value written at index 0x02 leaves it unlocked.
- R9: `io_rdata` changes only on a clock edge at which `io_rd` is high. A read of any address other than the data port, or any read while locked, returns 0xFF.
- R10: Unlocked reads of unimplemented indexes return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write byte |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Registered read byte, valid the cycle after `io_rd` |
| cfg_unlocked | output | 1 | High while the configuration space is unlocked |
| ldn_sel | output | 8 | Selected logical device |
| gpio_base | output | 16 | I/O base address held by the general-purpose I/O device |

## Verification
A key matcher that is one step off surfaces at the next key write, because `cfg_unlocked` rises a step early or never rises at all. A broken lock state shows on the very next data-port read as a value other than 0xFF, or as a register value where 0xFF was due. A wrong index or bank decode shows within one read, either as the wrong byte or as a `gpio_base` that changes after a write made with another device selected. The random traffic is biased toward key bytes, exit bytes and the implemented indexes, so the bench compares each of these outputs after every access.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int KEY_LEN = 4;

  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_REV     = 8'h22;
  localparam logic [7:0] IDX_BASE_HI = 8'h62;
  localparam logic [7:0] IDX_BASE_LO = 8'h63;
  localparam logic [7:0] IDX_EXIT    = 8'h02;
  localparam logic [7:0] EXIT_VAL    = 8'h02;

  // unlock key, in the order it must arrive
  function automatic logic [7:0] key_byte(input int step);
    case (step)
      0:       key_byte = 8'h87;
      1:       key_byte = 8'h01;
      default: key_byte = 8'h55;
    endcase
  endfunction
endpackage

// File: rtl/cfg_key_match.sv
module cfg_key_match
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  output logic       key_done
);
  localparam int STEP_W = $clog2(KEY_LEN);

  logic [STEP_W-1:0] step_q;
  logic              hit;
  logic              last;

  always_comb begin
    hit      = (byte_in == key_byte(int'(step_q)));
    last     = (int'(step_q) == KEY_LEN - 1);
    key_done = byte_vld && hit && last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (byte_vld) begin
      if (hit && !last)
        step_q <= step_q + 1'b1;
      else if (hit)
        step_q <= '0;
      else if (byte_in == key_byte(0))
        step_q <= STEP_W'(1);
      else
        step_q <= '0;
    end
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'hA5C3,
  parameter logic [3:0]  CHIP_REV = 4'h3,
  parameter logic [7:0]  GPIO_LDN = 8'h07,
  parameter int          BASE_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        idx,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [7:0]        ldn,
  output logic [BASE_W-1:0] base
);
  localparam int HI_W = BASE_W - 8;

  logic gpio_bank;
  assign gpio_bank = (ldn == GPIO_LDN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldn  <= '0;
      base <= '0;
    end else if (wr_en) begin
      if (idx == IDX_LDN)
        ldn <= wdata;
      if (gpio_bank && idx == IDX_BASE_HI)
        base[BASE_W-1:8] <= wdata[HI_W-1:0];
      if (gpio_bank && idx == IDX_BASE_LO)
        base[7:0] <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    case (idx)
      IDX_LDN:     rdata = ldn;
      IDX_ID_HI:   rdata = CHIP_ID[15:8];
      IDX_ID_LO:   rdata = CHIP_ID[7:0];
      IDX_REV:     rdata = {4'h0, CHIP_REV};
      IDX_BASE_HI: if (gpio_bank) rdata = 8'(base[BASE_W-1:8]);
      IDX_BASE_LO: if (gpio_bank) rdata = base[7:0];
      default:     rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] INDEX_ADDR = 16'h002E,
  parameter logic [15:0] DATA_ADDR  = 16'h002F,
  parameter logic [15:0] CHIP_ID    = 16'hA5C3,
  parameter logic [3:0]  CHIP_REV   = 4'h3,
  parameter logic [7:0]  GPIO_LDN   = 8'h07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic [7:0]  io_wdata,
  input  logic        io_wr,
  input  logic        io_rd,
  output logic [7:0]  io_rdata,
  output logic        cfg_unlocked,
  output logic [7:0]  ldn_sel,
  output logic [15:0] gpio_base
);
  logic       idx_wr, dat_wr, dat_rd;
  logic       key_done, exit_hit;
  logic [7:0] idx_q;
  logic [7:0] reg_rdata;

  always_comb begin
    idx_wr   = io_wr && (io_addr == INDEX_ADDR);
    dat_wr   = io_wr && (io_addr == DATA_ADDR);
    dat_rd   = io_rd && (io_addr == DATA_ADDR);
    exit_hit = cfg_unlocked && dat_wr && (idx_q == IDX_EXIT) && (io_wdata == EXIT_VAL);
  end

  cfg_key_match u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_vld (idx_wr && !cfg_unlocked),
    .byte_in  (io_wdata),
    .key_done (key_done)
  );

  cfg_regs #(
    .CHIP_ID  (CHIP_ID),
    .CHIP_REV (CHIP_REV),
    .GPIO_LDN (GPIO_LDN),
    .BASE_W   (16)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (dat_wr && cfg_unlocked),
    .idx   (idx_q),
    .wdata (io_wdata),
    .rdata (reg_rdata),
    .ldn   (ldn_sel),
    .base  (gpio_base)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_unlocked <= 1'b0;
      idx_q        <= '0;
      io_rdata     <= 8'hFF;
    end else begin
      if (key_done)
        cfg_unlocked <= 1'b1;
      else if (exit_hit)
        cfg_unlocked <= 1'b0;
      if (idx_wr && cfg_unlocked)
        idx_q <= io_wdata;
      if (io_rd)
        io_rdata <= (dat_rd && cfg_unlocked) ? reg_rdata : 8'hFF;
    end
  end
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter logic [15:0] INDEX_ADDR = 16'h002E,
  parameter logic [15:0] DATA_ADDR  = 16'h002F
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic [7:0]  io_wdata,
  input logic        io_wr,
  input logic        io_rd,
  input logic [7:0]  io_rdata,
  input logic        cfg_unlocked,
  input logic [7:0]  ldn_sel,
  input logic [15:0] gpio_base
);
  // R2
  unlock_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_unlocked) |-> $past(io_wr && io_addr == INDEX_ADDR && io_wdata == 8'h55));

  // R8
  lock_by_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_unlocked) |-> $past(io_wr && io_addr == DATA_ADDR && io_wdata == 8'h02));

  // R4
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_unlocked && io_wr && io_addr == DATA_ADDR) |=> ($stable(ldn_sel) && $stable(gpio_base)));

  // R4
  locked_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_unlocked && io_rd) |=> (io_rdata == 8'hFF));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));
endmodule

bind cfg_port_ctrl cfg_port_chk #(
  .INDEX_ADDR (INDEX_ADDR),
  .DATA_ADDR  (DATA_ADDR)
) i_cfg_port_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_addr      (io_addr),
  .io_wdata     (io_wdata),
  .io_wr        (io_wr),
  .io_rd        (io_rd),
  .io_rdata     (io_rdata),
  .cfg_unlocked (cfg_unlocked),
  .ldn_sel      (ldn_sel),
  .gpio_base    (gpio_base)
);

// File: tb/test_cfg_port_ctrl.sv
module test_cfg_port_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IDXP = 16'h002E;
  localparam logic [15:0] DATP = 16'h002F;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] io_addr = 0;
  logic [7:0]  io_wdata = 0;
  logic        io_wr = 0;
  logic        io_rd = 0;
  logic [7:0]  io_rdata;
  logic        cfg_unlocked;
  logic [7:0]  ldn_sel;
  logic [15:0] gpio_base;

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  bit         m_unl = 0;
  int         m_step = 0;
  logic [7:0] m_idx = 0, m_ldn = 0, m_rd = 8'hFF;
  logic [15:0] m_base = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_ctrl i_cfg_port_ctrl (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
    .cfg_unlocked(cfg_unlocked), .ldn_sel(ldn_sel), .gpio_base(gpio_base)
  );

  function automatic logic [7:0] kb(input int s);
    return (s == 0) ? 8'h87 : (s == 1) ? 8'h01 : 8'h55;
  endfunction

  function automatic logic [7:0] m_reg(input logic [7:0] ix);
    case (ix)
      8'h07: return m_ldn;
      8'h20: return 8'hA5;
      8'h21: return 8'hC3;
      8'h22: return 8'h03;
      8'h62: return (m_ldn == 8'h07) ? m_base[15:8] : 8'h00;
      8'h63: return (m_ldn == 8'h07) ? m_base[7:0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_write(input logic [15:0] a, input logic [7:0] d);
    if (a == IDXP) begin
      if (!m_unl) begin
        if (d == kb(m_step)) begin
          if (m_step == 3) begin m_unl = 1; m_step = 0; end
          else m_step++;
        end else m_step = (d == 8'h87) ? 1 : 0;
      end else m_idx = d;
    end else if (a == DATP && m_unl) begin
      if (m_idx == 8'h07) m_ldn = d;
      if (m_idx == 8'h62 && m_ldn == 8'h07) m_base[15:8] = d;
      if (m_idx == 8'h63 && m_ldn == 8'h07) m_base[7:0] = d;
      if (m_idx == 8'h02 && d == 8'h02) m_unl = 0;
    end
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " unlocked"}, 16'(cfg_unlocked), 16'(m_unl));
    chk({tag, " ldn"}, 16'(ldn_sel), 16'(m_ldn));
    chk({tag, " base"}, gpio_base, m_base);
    chk({tag, " rdata"}, 16'(io_rdata), 16'(m_rd));
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
    m_write(a, d);
  endtask

  task automatic rd(input logic [15:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1;
    @(negedge clk);
    io_rd = 0;
    m_rd = (a == DATP && m_unl) ? m_reg(m_idx) : 8'hFF;
  endtask

  task automatic unlock();
    for (int i = 0; i < 4; i++) wr(IDXP, kb(i));
  endtask

  task automatic rd_reg(input logic [7:0] ix, input logic [7:0] exp, input string tag);
    wr(IDXP, ix);
    rd(DATP);
    chk(tag, 16'(io_rdata), 16'(exp));
  endtask

  function automatic logic [7:0] pick(input int r);
    case (r % 12)
      0: return 8'h87; 1: return 8'h01; 2: return 8'h55; 3: return 8'h02;
      4: return 8'h07; 5: return 8'h20; 6: return 8'h21; 7: return 8'h22;
      8: return 8'h62; 9: return 8'h63; 10: return 8'h07;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1 reset");

    // R4: locked data access
    wr(IDXP, 8'h07);
    wr(DATP, 8'h05);
    rd(DATP);
    check_state("R4 locked");
    chk("R4 locked read", 16'(io_rdata), 16'h00FF);

    // R3: broken order does not unlock
    wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55); wr(IDXP, 8'h00); wr(IDXP, 8'h55);
    chk("R3 broken key", 16'(cfg_unlocked), 16'h0000);
    wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h87); wr(IDXP, 8'h01); wr(IDXP, 8'h55);
    chk("R2 not yet open", 16'(cfg_unlocked), 16'h0000);
    wr(IDXP, 8'h55);
    chk("R3 restart on 0x87", 16'(cfg_unlocked), 16'h0001);

    // R5, R4 earlier write ignored
    rd_reg(8'h07, 8'h00, "R4 ldn untouched while locked");
    wr(DATP, 8'h03);
    chk("R5 ldn out", 16'(ldn_sel), 16'h0003);
    rd_reg(8'h07, 8'h03, "R5 ldn readback");

    // R6
    rd_reg(8'h20, 8'hA5, "R6 id hi");
    rd_reg(8'h21, 8'hC3, "R6 id lo");
    rd_reg(8'h22, 8'h03, "R6 rev");
    wr(DATP, 8'hFF);
    rd_reg(8'h22, 8'h03, "R6 rev write ignored");

    // R7 other bank
    rd_reg(8'h62, 8'h00, "R7 base hidden");
    wr(DATP, 8'h44);
    chk("R7 write ignored off-bank", gpio_base, 16'h0000);
    wr(IDXP, 8'h07); wr(DATP, 8'h07);
    wr(IDXP, 8'h62); wr(DATP, 8'h12);
    wr(IDXP, 8'h63); wr(DATP, 8'h34);
    chk("R7 base out", gpio_base, 16'h1234);
    rd_reg(8'h62, 8'h12, "R7 base hi read");

    // R10
    rd_reg(8'h40, 8'h00, "R10 unimplemented");

    // R9: index-port read gives FF
    rd(IDXP);
    chk("R9 index read", 16'(io_rdata), 16'h00FF);

    // R8
    wr(IDXP, 8'h02); wr(DATP, 8'h03);
    chk("R8 wrong exit value", 16'(cfg_unlocked), 16'h0001);
    wr(DATP, 8'h02);
    chk("R8 exit", 16'(cfg_unlocked), 16'h0000);
    rd(DATP);
    chk("R4 read after exit", 16'(io_rdata), 16'h00FF);
    check_state("R8 post exit");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom % 20);
      if (r == 0) unlock();
      else if (r < 8) wr(IDXP, pick(int'($urandom)));
      else if (r < 13) wr(DATP, pick(int'($urandom)));
      else if (r < 18) rd(DATP);
      else if (r == 18) rd(IDXP);
      else wr(16'h0080, 8'($urandom));
      check_state("R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule